// File: doc/BRIEF.md
# Branch Condition and Link Unit

This unit settles conditional branches for a 32-bit processor. Each request carries the address of the branch, the indices and values of two source registers, a 16-bit signed word offset and a 3-bit branch kind. One clock edge later the unit reports whether the branch is taken and the address of the next instruction. For the branch-and-link kinds it also issues a write of the return address into the link register.

Two families of test are covered. The pair tests compare the two source registers for equality or inequality. The zero tests classify the first source register as negative, zero or positive, using only its sign bit and a zero detect. A register index of zero always supplies the value zero, whatever is presented on the value input. The link write is independent of the branch outcome: a branch-and-link that falls through still records its return address.

Top module: `brcl_unit`

## Requirements
- R1: Kind 0 (equal) is taken when the two effective operands match, and kind 1 (not equal) is taken when they differ.
- R2: Kind 2 is taken when the effective first operand, read as two's complement, is at most zero, and kind 3 is taken when it is above zero.
- R3: Kind 4 is taken when the effective first operand is negative, and kind 5 is taken when it is zero or positive.
- R4: Kinds 6 and 7 take the same decisions as kinds 4 and 5. They always raise linkWrEn with linkAddr equal to 31 and linkData equal to the branch address plus 4, whether the branch is taken or not. Kinds 0 to 5 never raise linkWrEn.
- R5: A source index of zero makes that operand zero, ignoring the supplied value.
- R6: A taken branch sets nextPc to the branch address plus 4 plus the sign-extended offset shifted left by two, modulo 2^32.
- R7: A branch that is not taken sets nextPc to the branch address plus 4, modulo 2^32.
- R8: outValid is high in exactly the cycle after each cycle with reqValid high. Results appear in request order, back-to-back requests included. linkWrEn is never high while outValid is low.
- R9: While rstN is low, outValid, brTaken and linkWrEn are 0 and nextPc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| brKind | input | 3 | Branch kind, encoded as in R1 to R4 |
| pcIn | input | 32 | Address of the branch instruction |
| rsIdx | input | 5 | Index of the first source register |
| rsVal | input | 32 | Value read for the first source register |
| rtIdx | input | 5 | Index of the second source register |
| rtVal | input | 32 | Value read for the second source register |
| offset | input | 16 | Signed word offset |
| outValid | output | 1 | Result present this cycle |
| brTaken | output | 1 | Branch decision |
| nextPc | output | 32 | Address of the next instruction |
| linkWrEn | output | 1 | Write request to the link register |
| linkAddr | output | 5 | Index of the link register (31) |
| linkData | output | 32 | Return address to be written |

## Verification
The redirect to the branch target and the link write can fall in the same cycle. A taken kind 6 or 7 request must then present the target on nextPc and, in the same cycle, the fall-through address on linkData. The bench provokes this with taken and not-taken link kinds issued back to back, with wrap-around addresses and negative offsets among them. Each result cycle is judged field by field against a scoreboard entry computed from R4, R6 and R7, so that nextPc and linkData are known to differ exactly when the branch is taken.

// File: rtl/brcl_pkg.sv
package brcl_pkg;

  typedef enum logic [2:0] {
    BK_EQ   = 3'd0,
    BK_NE   = 3'd1,
    BK_LEZ  = 3'd2,
    BK_GTZ  = 3'd3,
    BK_LTZ  = 3'd4,
    BK_GEZ  = 3'd5,
    BK_LTZL = 3'd6,
    BK_GEZL = 3'd7
  } brKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic eqMode;    // use the register-pair equality result
    logic wantEq;    // taken on equality (else on difference)
    logic takeNeg;   // zero test: taken when operand negative
    logic takeZero;  // zero test: taken when operand zero
    logic takePos;   // zero test: taken when operand positive
    logic link;      // request a link write
  } brStrobe_t;

endpackage

// File: rtl/brcl_ctrl.sv
module brcl_ctrl
  import brcl_pkg::*;
(
  input  logic [2:0] kindIn,
  output brStrobe_t  strobe
);

  brKind_e kind;
  assign kind = brKind_e'(kindIn);

  always_comb begin
    strobe = '0;
    unique case (kind)
      BK_EQ:   begin strobe.eqMode = 1'b1; strobe.wantEq = 1'b1; end
      BK_NE:   begin strobe.eqMode = 1'b1; strobe.wantEq = 1'b0; end
      BK_LEZ:  begin strobe.takeNeg = 1'b1; strobe.takeZero = 1'b1; end
      BK_GTZ:  begin strobe.takePos = 1'b1; end
      BK_LTZ:  begin strobe.takeNeg = 1'b1; end
      BK_GEZ:  begin strobe.takeZero = 1'b1; strobe.takePos = 1'b1; end
      BK_LTZL: begin strobe.takeNeg = 1'b1; strobe.link = 1'b1; end
      BK_GEZL: begin strobe.takeZero = 1'b1; strobe.takePos = 1'b1; strobe.link = 1'b1; end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/brcl_cmp.sv
module brcl_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            isEq,
  output logic            aNeg,
  output logic            aZero
);

  assign isEq  = (opA == opB);
  assign aNeg  = opA[XLEN-1];
  assign aZero = ~|opA;

endmodule

// File: rtl/brcl_datapath.sv
module brcl_datapath
  import brcl_pkg::*;
#(
  parameter int  XLEN     = 32,
  parameter int  OFFW     = 16,
  parameter int  IDXW     = 5,
  parameter bit  ZERO_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  brStrobe_t       strobe,
  input  logic [XLEN-1:0] pcIn,
  input  logic [IDXW-1:0] rsIdx,
  input  logic [XLEN-1:0] rsVal,
  input  logic [IDXW-1:0] rtIdx,
  input  logic [XLEN-1:0] rtVal,
  input  logic [OFFW-1:0] offset,
  output logic            outValid,
  output logic            brTaken,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWrEn,
  output logic [XLEN-1:0] linkData
);

  localparam int EXTW = XLEN - OFFW - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] rsEff, rtEff;
  logic [XLEN-1:0] offExt, pcPlus4, brTarget;
  logic            isEq, rsNeg, rsZero, rsPos, condHit;

  // Operand masking for the hardwired zero register
  generate
    if (ZERO_REG) begin : g_zeroReg
      assign rsEff = (rsIdx == '0) ? '0 : rsVal;
      assign rtEff = (rtIdx == '0) ? '0 : rtVal;
    end else begin : g_plainReg
      assign rsEff = rsVal;
      assign rtEff = rtVal;
    end
  endgenerate

  brcl_cmp #(.XLEN(XLEN)) u_cmp (
    .opA  (rsEff),
    .opB  (rtEff),
    .isEq (isEq),
    .aNeg (rsNeg),
    .aZero(rsZero)
  );

  assign rsPos = ~rsNeg & ~rsZero;

  always_comb begin
    if (strobe.eqMode) condHit = (isEq == strobe.wantEq);
    else condHit = (rsNeg & strobe.takeNeg) | (rsZero & strobe.takeZero) |
                   (rsPos & strobe.takePos);
  end

  assign offExt   = {{EXTW{offset[OFFW-1]}}, offset, 2'b00};
  assign pcPlus4  = pcIn + STEP;
  assign brTarget = pcPlus4 + offExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      brTaken  <= 1'b0;
      nextPc   <= '0;
      linkWrEn <= 1'b0;
      linkData <= '0;
    end else begin
      outValid <= reqValid;
      linkWrEn <= reqValid & strobe.link;
      if (reqValid) begin
        brTaken  <= condHit;
        nextPc   <= condHit ? brTarget : pcPlus4;
        linkData <= pcPlus4;
      end
    end
  end

  // R8
  req_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R8
  out_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid));

  // R8
  link_in_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> outValid);

  // R7
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !brTaken) |-> (nextPc == $past(pcIn) + STEP));

  // R4
  link_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> (linkData == $past(pcIn) + STEP));

  // R4
  link_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> ($past(strobe.link) && !$past(strobe.eqMode)));

endmodule

// File: rtl/brcl_unit.sv
module brcl_unit
  import brcl_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFFW     = 16,
  parameter int IDXW     = 5,
  parameter int LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      brKind,
  input  logic [XLEN-1:0] pcIn,
  input  logic [IDXW-1:0] rsIdx,
  input  logic [XLEN-1:0] rsVal,
  input  logic [IDXW-1:0] rtIdx,
  input  logic [XLEN-1:0] rtVal,
  input  logic [OFFW-1:0] offset,
  output logic            outValid,
  output logic            brTaken,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWrEn,
  output logic [IDXW-1:0] linkAddr,
  output logic [XLEN-1:0] linkData
);

  brStrobe_t strobe;

  brcl_ctrl u_ctrl (
    .kindIn(brKind),
    .strobe(strobe)
  );

  brcl_datapath #(
    .XLEN    (XLEN),
    .OFFW    (OFFW),
    .IDXW    (IDXW),
    .ZERO_REG(1'b1)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobe  (strobe),
    .pcIn    (pcIn),
    .rsIdx   (rsIdx),
    .rsVal   (rsVal),
    .rtIdx   (rtIdx),
    .rtVal   (rtVal),
    .offset  (offset),
    .outValid(outValid),
    .brTaken (brTaken),
    .nextPc  (nextPc),
    .linkWrEn(linkWrEn),
    .linkData(linkData)
  );

  assign linkAddr = IDXW'(LINK_REG);

endmodule

// File: tb/brcl_unit_bench.sv
`timescale 1ns/1ps
module brcl_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  brKind = '0;
  logic [31:0] pcIn = '0, rsVal = '0, rtVal = '0;
  logic [4:0]  rsIdx = '0, rtIdx = '0;
  logic [15:0] offset = '0;
  logic        outValid, brTaken, linkWrEn;
  logic [31:0] nextPc, linkData;
  logic [4:0]  linkAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic        link;
    logic [31:0] ret;
    string       req;
  } expItem_t;

  expItem_t sb[$];

  always #2.5 clk = ~clk;

  brcl_unit u_brcl_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .brKind(brKind),
    .pcIn(pcIn), .rsIdx(rsIdx), .rsVal(rsVal), .rtIdx(rtIdx), .rtVal(rtVal),
    .offset(offset), .outValid(outValid), .brTaken(brTaken), .nextPc(nextPc),
    .linkWrEn(linkWrEn), .linkAddr(linkAddr), .linkData(linkData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: apply one request and push its expected result
  task automatic issue(input logic [2:0] k, input logic [31:0] pc,
                       input logic [4:0] rsI, input logic [31:0] rsV,
                       input logic [4:0] rtI, input logic [31:0] rtV,
                       input logic [15:0] off, input string req);
    expItem_t e;
    logic [31:0] a, b, seq;
    logic t;
    a = (rsI == 5'd0) ? 32'd0 : rsV;
    b = (rtI == 5'd0) ? 32'd0 : rtV;
    case (k)
      3'd0: t = (a == b);
      3'd1: t = (a != b);
      3'd2: t = ($signed(a) <= 0);
      3'd3: t = ($signed(a) > 0);
      3'd4, 3'd6: t = ($signed(a) < 0);
      default: t = ($signed(a) >= 0);
    endcase
    seq = pc + 32'd4;
    e.taken = t;
    e.npc = t ? seq + {{14{off[15]}}, off, 2'b00} : seq;
    e.link = (k >= 3'd6);
    e.ret = seq;
    e.req = req;
    @(negedge clk);
    reqValid = 1'b1; brKind = k; pcIn = pc;
    rsIdx = rsI; rsVal = rsV; rtIdx = rtI; rtVal = rtV; offset = off;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      brKind = 3'd7; rsVal = 32'hDEAD_BEEF;
    end
  endtask

  // Monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "result without request", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = sb.pop_front();
          chk(brTaken == e.taken, e.req, "brTaken", 32'(brTaken), 32'(e.taken));
          chk(nextPc == e.npc, e.req, "nextPc", nextPc, e.npc);
          chk(linkWrEn == e.link, e.req, "linkWrEn (R4)", 32'(linkWrEn), 32'(e.link));
          if (e.link) begin
            chk(linkData == e.ret, "R4", "linkData", linkData, e.ret);
            chk(linkAddr == 5'd31, "R4", "linkAddr", 32'(linkAddr), 32'd31);
          end
        end
      end else begin
        chk(linkWrEn == 1'b0, "R8", "linkWrEn while idle", 32'(linkWrEn), 32'd0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(outValid == 1'b0, "R9", "outValid", 32'(outValid), 32'd0);
    chk(brTaken == 1'b0, "R9", "brTaken", 32'(brTaken), 32'd0);
    chk(linkWrEn == 1'b0, "R9", "linkWrEn", 32'(linkWrEn), 32'd0);
    chk(nextPc == 32'd0, "R9", "nextPc", nextPc, 32'd0);
    rstN = 1'b1;
    idle(2);

    // R1 pair tests
    issue(3'd0, 32'h0000_1000, 5'd2, 32'h1234_5678, 5'd3, 32'h1234_5678, 16'h0010, "R1");
    issue(3'd0, 32'h0000_1000, 5'd2, 32'h1234_5678, 5'd3, 32'h1234_5679, 16'h0010, "R1");
    issue(3'd1, 32'h0000_2000, 5'd4, 32'h0000_0001, 5'd5, 32'h8000_0001, 16'h0003, "R1");
    issue(3'd1, 32'h0000_2000, 5'd4, 32'hFFFF_FFFF, 5'd5, 32'hFFFF_FFFF, 16'h0003, "R1");
    idle(1);
    // R2 at-most-zero / above-zero
    issue(3'd2, 32'h0040_0000, 5'd7, 32'h0000_0000, 5'd1, 32'h5, 16'hFFFE, "R2");
    issue(3'd2, 32'h0040_0000, 5'd7, 32'h8000_0000, 5'd1, 32'h5, 16'h0100, "R2");
    issue(3'd2, 32'h0040_0000, 5'd7, 32'h0000_0001, 5'd1, 32'h5, 16'h0100, "R2");
    issue(3'd3, 32'h0040_0010, 5'd8, 32'h7FFF_FFFF, 5'd1, 32'h5, 16'h0020, "R2");
    issue(3'd3, 32'h0040_0010, 5'd8, 32'h0000_0000, 5'd1, 32'h5, 16'h0020, "R2");
    issue(3'd3, 32'h0040_0010, 5'd8, 32'hFFFF_FFFF, 5'd1, 32'h5, 16'h0020, "R2");
    // R3 negative / non-negative
    issue(3'd4, 32'h0001_0000, 5'd9, 32'hFFFF_FF00, 5'd0, 32'h0, 16'h0004, "R3");
    issue(3'd4, 32'h0001_0000, 5'd9, 32'h0000_0000, 5'd0, 32'h0, 16'h0004, "R3");
    issue(3'd5, 32'h0001_0100, 5'd9, 32'h0000_0000, 5'd0, 32'h0, 16'h8000, "R3");
    issue(3'd5, 32'h0001_0100, 5'd9, 32'h8000_0000, 5'd0, 32'h0, 16'h8000, "R3");
    idle(2);
    // R4 link kinds: taken and not taken, back to back
    issue(3'd6, 32'h0000_3000, 5'd10, 32'h8000_0000, 5'd0, 32'h0, 16'h0040, "R4");
    issue(3'd6, 32'h0000_3004, 5'd10, 32'h0000_0040, 5'd0, 32'h0, 16'h0040, "R4");
    issue(3'd7, 32'h0000_3008, 5'd10, 32'h0000_0000, 5'd0, 32'h0, 16'hFFF0, "R4");
    issue(3'd7, 32'hFFFF_FFFC, 5'd10, 32'hC000_0000, 5'd0, 32'h0, 16'hFFF0, "R4");
    issue(3'd7, 32'hFFFF_FFF8, 5'd10, 32'h0000_0003, 5'd0, 32'h0, 16'h0002, "R4");
    idle(1);
    // R5 index zero ignores supplied value
    issue(3'd0, 32'h0000_5000, 5'd0, 32'hAAAA_AAAA, 5'd0, 32'h5555_5555, 16'h0008, "R5");
    issue(3'd3, 32'h0000_5000, 5'd0, 32'h0000_0007, 5'd3, 32'h0, 16'h0008, "R5");
    issue(3'd4, 32'h0000_5000, 5'd0, 32'hFFFF_FFFF, 5'd3, 32'h0, 16'h0008, "R5");
    issue(3'd1, 32'h0000_5000, 5'd6, 32'h0000_0000, 5'd0, 32'h1111_1111, 16'h0008, "R5");
    // R6 target wrap and most negative offset; R7 fall-through wrap
    issue(3'd0, 32'hFFFF_FFF0, 5'd1, 32'h1, 5'd2, 32'h1, 16'h0007, "R6");
    issue(3'd0, 32'h0000_0010, 5'd1, 32'h1, 5'd2, 32'h1, 16'h8000, "R6");
    issue(3'd0, 32'h0000_0100, 5'd1, 32'h1, 5'd2, 32'h1, 16'h7FFF, "R6");
    issue(3'd1, 32'hFFFF_FFFC, 5'd1, 32'h1, 5'd2, 32'h1, 16'h0007, "R7");
    idle(4);
    chk(sb.size() == 0, "R8", "pending results", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule